// File: doc/BRIEF.md
# HDLC Frame Transmitter with Abort Handling

This block turns bytes from a small on-chip queue into a bit-serial HDLC line, one bit per clock. Software writes each byte together with an end-of-frame tag. Tag 0 means the byte continues the current frame. Tag 1 marks the last data byte. Writing the first byte with tag 0 while the line is idle starts a frame, and no start command is needed. The transmitter sends an opening flag, then the bytes with zero-bit insertion. After the tagged last byte it appends the 16-bit check sequence and a closing flag by itself. When no frame is waiting, the line carries either continuous ones or back-to-back flags.

The block has six states:
- `S_MARK` drives ones. It moves to `S_FLAG` once transmission is enabled and either a byte is queued or flag fill is selected.
- `S_FLAG` sends one 0x7E flag. At the end of the flag it goes to `S_DATA` if a byte is queued and this flag may open a frame. Otherwise it sends another flag or falls back to `S_MARK`.
- `S_DATA` serialises bytes. At each byte end it goes to `S_FCS` after the last byte, pops the next byte if one is queued, or goes to `S_ABORT` on underrun.
- `S_FCS` sends the check sequence and then goes to `S_FLAG` for the closing flag.
- `S_ABORT` sends 8 or 16 ones, then takes the same idle decision as `S_MARK`.
- `S_HOLD` is entered from any state while clear-to-send is lost. It drives ones and returns to `S_MARK` when clear-to-send comes back.

Three events break a frame: a queue that runs dry mid-frame, a software abort command, and loss of clear-to-send. Each one ends the frame on the line and sets a sticky status bit. A one-cycle pulse asks the surrounding logic to clear its transmit-enable bit when clear-to-send is lost inside a frame.

Top module: `hdlc_tx`

## Requirements
- R1: With `idle_mark`=1, or with `tx_en`=0, an idle line is constant 1. With `idle_mark`=0 and `tx_en`=1, the idle line repeats the flag 0x7E, sent LSB first.
- R2: Writing a byte with `wr_last`=0 while idle starts a frame on its own. The line sends an opening flag, then each byte LSB first.
- R3: The byte written with `wr_last`=1 is the last data byte. The block then appends the complement of a CRC-16 over the data and a closing flag. The CRC uses polynomial x^16+x^12+x^5+1, bit-reflected, preset to 0xFFFF. Its low byte goes first and each byte is sent LSB first. Example: payload "123456789" gives check bytes 0x6E then 0x90.
- R4: A 0 is inserted after every five consecutive 1s in data and check bits. Flags, aborts and idle ones are never stuffed.
- R5: With `shared_flag`=1, the closing flag of a frame also opens the next frame when that frame is already queued. With `shared_flag`=0, a separate opening flag follows the closing flag.
- R6: The queue holds 8 entries of byte plus tag. `fifo_room` is 1 while at least one entry is free. A write while the queue is full is dropped.
- R7: If the queue is empty at the end of a non-last byte, the frame is ended with exactly 8 ones and `underrun` is set. The idle pattern of R1 then follows.
- R8: A pulse on `abort_req` ends the frame at once, flushes the queue and sets `aborted`. The abort is exactly 8 ones with `abort_ext`=0, or 16 ones with `abort_ext`=1.
- R9: While `cts_n` is 1, `txd` is 1 from the second clock on. If this happens during data or check bits, the queue is flushed, `aborted` is set and `tx_en_drop` pulses for one cycle.
- R10: `underrun` and `aborted` stay set until `status_clr` is 1.
- R11: After reset, `txd`=1, `fifo_room`=1, `underrun`=0 and `aborted`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| idle_mark | input | 1 | 1: idle ones, 0: flag fill |
| shared_flag | input | 1 | 1: one flag between back-to-back frames |
| abort_req | input | 1 | Software abort command pulse |
| abort_ext | input | 1 | 1: 16-one abort instead of 8 |
| cts_n | input | 1 | Clear-to-send, active low |
| status_clr | input | 1 | Clears the sticky status bits |
| wr_valid | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | 1: byte terminates the frame |
| txd | output | 1 | Serial line |
| fifo_room | output | 1 | Queue has a free entry |
| underrun | output | 1 | Sticky underrun status |
| aborted | output | 1 | Sticky abort status (software abort or clear-to-send loss) |
| tx_en_drop | output | 1 | One-cycle request to clear transmit enable |

## Verification
A bench-side receiver destuffs the line, splits it at flags and measures runs of ones. Payloads are chosen to separate the cases:
- All-ones bytes and bytes that hold 0x7E show whether stuffing works, since a missing stuff bit reads as an abort.
- Zero bytes placed before an abort make the measured run of ones exactly the abort length.
- The "123456789" frame pins the check-sequence bit order against a known value.

Flag counts tell a shared flag apart from separate flags. Frame length tells a dropped overflow write apart from an overwrite. A late underrun after an abort shows a queue that was not flushed.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [2:0] {
        S_MARK,
        S_FLAG,
        S_DATA,
        S_FCS,
        S_ABORT,
        S_HOLD
    } tx_state_t;

    localparam logic [7:0]  FLAG_PATTERN  = 8'h7E;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [2:0]  STUFF_RUN     = 3'd5;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr, rd_ptr;
    logic [AW:0]  level;

    assign level = wr_ptr - rd_ptr;
    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign dout  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wr_ptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));
    // R6: the serializer never pops an empty queue
    a_r6_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int          W      = 16,
    parameter logic [15:0] POLY   = 16'h8408,
    parameter logic [15:0] PRESET = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc_nxt
);
    logic [W-1:0] crc_q;

    always_comb begin
        crc_nxt = {1'b0, crc_q[W-1:1]};
        if (crc_q[0] ^ din) crc_nxt = crc_nxt ^ POLY[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || init) crc_q <= PRESET[W-1:0];
        else if (en)        crc_q <= crc_nxt;
    end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int FIFO_DEPTH    = 8,
    parameter int CRC_W         = 16,
    parameter int ABORT_LEN     = 8,
    parameter int ABORT_EXT_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              idle_mark,
    input  logic              shared_flag,
    input  logic              abort_req,
    input  logic              abort_ext,
    input  logic              cts_n,
    input  logic              status_clr,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              txd,
    output logic              fifo_room,
    output logic              underrun,
    output logic              aborted,
    output logic              tx_en_drop
);
    localparam int CNT_MAX = (ABORT_EXT_LEN > CRC_W) ? ABORT_EXT_LEN : CRC_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int ENTRY_W = DATA_W + 1;

    tx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d, alen_q, alen_d;
    logic [CRC_W-1:0]   shreg_q, shreg_d;
    logic [2:0]         ones_q, ones_d, ones_after;
    logic               last_q, last_d, open_ok_q, open_ok_d;
    logic               fifo_pop, fifo_flush, fifo_empty, fifo_full;
    logic [ENTRY_W-1:0] fifo_dout;
    logic               crc_init, crc_en;
    logic [CRC_W-1:0]   crc_nxt;
    logic               set_underrun, set_abort, drop_pulse;
    logic               in_frame, stuff, queued, want_flag, out_bit;

    hdlc_tx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .din({wr_last, wr_data}),
        .pop(fifo_pop), .flush(fifo_flush), .dout(fifo_dout),
        .empty(fifo_empty), .full(fifo_full)
    );

    hdlc_tx_crc #(.W(CRC_W), .POLY(CRC_POLY_REFL), .PRESET(CRC_PRESET)) u_crc (
        .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
        .din(shreg_q[0]), .crc_nxt(crc_nxt)
    );

    assign fifo_room  = !fifo_full;
    assign queued     = !fifo_empty;
    assign in_frame   = (state_q == S_DATA) || (state_q == S_FCS);
    assign stuff      = in_frame && (ones_q == STUFF_RUN);
    assign ones_after = shreg_q[0] ? ones_q + 3'd1 : 3'd0;
    assign want_flag  = tx_en && (queued || !idle_mark);

    // next-state and datapath control
    always_comb begin
        state_d = state_q;  cnt_d = cnt_q;  alen_d = alen_q;
        shreg_d = shreg_q;  ones_d = ones_q;
        last_d  = last_q;   open_ok_d = open_ok_q;
        fifo_pop = 1'b0; fifo_flush = 1'b0; crc_init = 1'b0; crc_en = 1'b0;
        set_underrun = 1'b0; set_abort = 1'b0; drop_pulse = 1'b0;
        if (cts_n && state_q != S_HOLD) begin
            state_d = S_HOLD;
            if (in_frame) begin
                set_abort = 1'b1; drop_pulse = 1'b1; fifo_flush = 1'b1;
            end
        end else if (abort_req && state_q != S_HOLD) begin
            state_d    = S_ABORT;
            cnt_d      = '0;
            alen_d     = abort_ext ? CNT_W'(ABORT_EXT_LEN - 1) : CNT_W'(ABORT_LEN - 1);
            fifo_flush = 1'b1;
            set_abort  = 1'b1;
        end else begin
            unique case (state_q)
                S_MARK: if (want_flag) begin
                    state_d = S_FLAG; cnt_d = '0; open_ok_d = 1'b1;
                end
                S_FLAG: if (cnt_q == CNT_W'(7)) begin
                    if (tx_en && queued && open_ok_q) begin
                        state_d  = S_DATA;  cnt_d = '0;  ones_d = '0;
                        fifo_pop = 1'b1;    crc_init = 1'b1;
                        shreg_d  = CRC_W'(fifo_dout[DATA_W-1:0]);
                        last_d   = fifo_dout[DATA_W];
                    end else if (want_flag) begin
                        cnt_d = '0; open_ok_d = 1'b1;
                    end else begin
                        state_d = S_MARK;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                S_DATA: if (stuff) begin
                    ones_d = '0;
                end else begin
                    crc_en  = 1'b1;
                    ones_d  = ones_after;
                    shreg_d = shreg_q >> 1;
                    cnt_d   = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(DATA_W - 1)) begin
                        cnt_d = '0;
                        if (last_q) begin
                            state_d = S_FCS;
                            shreg_d = ~crc_nxt;
                        end else if (queued) begin
                            fifo_pop = 1'b1;
                            shreg_d  = CRC_W'(fifo_dout[DATA_W-1:0]);
                            last_d   = fifo_dout[DATA_W];
                        end else begin
                            state_d      = S_ABORT;
                            alen_d       = CNT_W'(ABORT_LEN - 1);
                            set_underrun = 1'b1;
                        end
                    end
                end
                S_FCS: if (stuff) begin
                    ones_d = '0;
                    if (cnt_q == CNT_W'(CRC_W)) begin
                        state_d = S_FLAG; cnt_d = '0; open_ok_d = shared_flag;
                    end
                end else begin
                    ones_d  = ones_after;
                    shreg_d = shreg_q >> 1;
                    cnt_d   = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(CRC_W - 1) && ones_after != STUFF_RUN) begin
                        state_d = S_FLAG; cnt_d = '0; open_ok_d = shared_flag;
                    end
                end
                S_ABORT: if (cnt_q == alen_q) begin
                    cnt_d = '0; open_ok_d = 1'b1;
                    state_d = want_flag ? S_FLAG : S_MARK;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                S_HOLD: if (!cts_n) state_d = S_MARK;
                default: state_d = S_MARK;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            S_FLAG:         out_bit = FLAG_PATTERN[cnt_q[2:0]];
            S_DATA, S_FCS:  out_bit = stuff ? 1'b0 : shreg_q[0];
            default:        out_bit = 1'b1;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_MARK;  cnt_q <= '0;  alen_q <= '0;
            shreg_q <= '0;      ones_q <= '0;
            last_q  <= 1'b0;    open_ok_q <= 1'b1;
        end else begin
            state_q <= state_d; cnt_q <= cnt_d;   alen_q <= alen_d;
            shreg_q <= shreg_d; ones_q <= ones_d;
            last_q  <= last_d;  open_ok_q <= open_ok_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd <= 1'b1; underrun <= 1'b0; aborted <= 1'b0; tx_en_drop <= 1'b0;
        end else begin
            txd        <= out_bit;
            underrun   <= set_underrun | (underrun & !status_clr);
            aborted    <= set_abort    | (aborted  & !status_clr);
            tx_en_drop <= drop_pulse;
        end
    end

    // R9: line stays high while clear-to-send is lost
    a_r9_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_n && $past(cts_n)) |=> txd);
    // R9: enable-drop request is a single pulse
    a_r9_drop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_drop |=> !tx_en_drop);
    // R4: run of ones in stuffed fields never passes five
    a_r4_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> ones_q <= STUFF_RUN);
    // R1: every flag begins with a 0 on the line
    a_r1_flag_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLAG && cnt_q == '0 && !cts_n && !abort_req) |=> !txd);
    // R8: abort counter stays inside its selected length
    a_r8_abort_len: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_ABORT |-> cnt_q <= alen_q);
    // R10: sticky underrun holds until cleared
    a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !status_clr) |=> underrun);
    // R7: underrun is only raised together with an abort sequence
    a_r7_underrun_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> state_q == S_ABORT);
endmodule

// File: tb/tb_hdlc_tx.sv
module tb_hdlc_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b1, idle_mark = 1'b1, shared_flag = 1'b0;
    logic abort_req = 1'b0, abort_ext = 1'b0, cts_n = 1'b0, status_clr = 1'b0;
    logic wr_valid = 1'b0, wr_last = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic txd, fifo_room, underrun, aborted, tx_en_drop;

    always #10 clk = ~clk;

    hdlc_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .idle_mark(idle_mark),
        .shared_flag(shared_flag), .abort_req(abort_req), .abort_ext(abort_ext),
        .cts_n(cts_n), .status_clr(status_clr), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_last(wr_last), .txd(txd), .fifo_room(fifo_room),
        .underrun(underrun), .aborted(aborted), .tx_en_drop(tx_en_drop)
    );

    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- line receiver model ----------------
    bit rx_on = 1'b0, hunting = 1'b1;
    int ones = 0, run = 0, last_run = 0, blen = 0;
    int flags = 0, aborts = 0, rx_count = 0, bad_frames = 0, zeros_seen = 0;
    logic rxbuf [0:1023];
    logic [7:0] rx_bytes [0:63];
    int rx_len = 0;
    bit rx_crc_ok = 1'b0;
    int drops = 0;

    function automatic logic [15:0] fcs_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int j = 0; j < n; j++)
            for (int k = 0; k < 8; k++)
                c = (c[0] ^ rx_bytes[j][k]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        return ~c;
    endfunction

    always @(negedge clk) begin
        if (tx_en_drop) drops++;
        if (rx_on) begin
            if (!txd) zeros_seen++;
            if (txd) begin
                run++; ones++;
                if (!hunting) begin rxbuf[blen] = 1'b1; blen++; end
                if (ones == 7) begin
                    if (!hunting && blen > 7) aborts++;
                    hunting = 1'b1; blen = 0;
                end
            end else begin
                if (run >= 7) last_run = run;
                run = 0;
                if (ones == 6) begin
                    flags++;
                    if (!hunting && blen > 7) begin
                        int n;
                        n = blen - 7;
                        if (n % 8 == 0 && n >= 24) begin
                            logic [15:0] f;
                            rx_len = n / 8;
                            for (int j = 0; j < rx_len; j++)
                                for (int k = 0; k < 8; k++)
                                    rx_bytes[j][k] = rxbuf[8*j+k];
                            f = fcs_of(rx_len - 2);
                            rx_crc_ok = (f == {rx_bytes[rx_len-1], rx_bytes[rx_len-2]});
                            rx_count++;
                        end else bad_frames++;
                    end
                    hunting = 1'b0; blen = 0;
                end else if (ones == 5 && !hunting) begin
                    // inserted zero, discarded
                end else if (!hunting) begin
                    rxbuf[blen] = 1'b0; blen++;
                end
                ones = 0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic push(input logic [7:0] d, input logic l, input bit wait_room);
        if (wait_room) while (!fifo_room) @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_last = l;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic wait_frame(input int start);
        for (int i = 0; i < 800 && rx_count == start; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_status();
        status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    endtask

    // {len[3:0], idle_mark, shared, 2'b0, b0, b1, b2, b3}
    localparam logic [39:0] VEC [0:5] = '{
        40'h18_A5_00_00_00,
        40'h40_FF_FF_FF_FF,
        40'h3C_7E_7E_3F_00,
        40'h24_00_F8_00_00,
        40'h48_1F_BE_FC_01,
        40'h20_55_AA_00_00
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(txd == 1'b1 && fifo_room && !underrun && !aborted, "R11 reset outputs",
              {txd, fifo_room, underrun, aborted}, 4'b1100);
        rx_on = 1'b1;

        // R1 mark idle
        idle(10);
        begin
            int z0, f0;
            z0 = zeros_seen; f0 = flags;
            idle(80);
            check(zeros_seen == z0 && flags == f0, "R1 mark idle ones", zeros_seen - z0, 0);
            // R1 flag fill
            idle_mark = 1'b0;
            idle(12);
            f0 = flags;
            idle(80);
            check(flags - f0 >= 9 && flags - f0 <= 11, "R1 flag fill rate", flags - f0, 10);
        end

        // R2 R3 R4 table of frames
        for (int v = 0; v < 6; v++) begin
            int len, start, bad0, ab0;
            bit ok;
            len = int'(VEC[v][39:36]);
            idle_mark = VEC[v][35];
            shared_flag = VEC[v][34];
            idle(20);
            start = rx_count; bad0 = bad_frames; ab0 = aborts;
            for (int i = 0; i < len; i++)
                push(VEC[v][31-8*i -: 8], i == len - 1, 1'b1);
            wait_frame(start);
            ok = (rx_count == start + 1) && (rx_len == len + 2) && rx_crc_ok
                 && (bad_frames == bad0) && (aborts == ab0);
            for (int i = 0; i < len; i++)
                if (rx_bytes[i] != VEC[v][31-8*i -: 8]) ok = 1'b0;
            check(ok, $sformatf("R2 R3 R4 vector %0d", v), rx_len, len + 2);
        end

        // R3 known check value
        begin
            int start;
            idle_mark = 1'b0;
            idle(20);
            start = rx_count;
            for (int i = 0; i < 9; i++) push(8'h31 + 8'(i), i == 8, 1'b1);
            wait_frame(start);
            check(rx_len == 11 && rx_bytes[9] == 8'h6E && rx_bytes[10] == 8'h90,
                  "R3 fcs of 123456789", {rx_bytes[10], rx_bytes[9]}, 16'h906E);
        end

        // R5 shared and separate flags between queued frames
        for (int s = 0; s < 2; s++) begin
            int f0, r0;
            idle_mark = 1'b1; shared_flag = (s == 0);
            idle(40);
            f0 = flags; r0 = rx_count;
            push(8'h11, 1'b0, 1'b1); push(8'h22, 1'b1, 1'b1);
            push(8'h33, 1'b0, 1'b1); push(8'h44, 1'b1, 1'b1);
            idle(250);
            check(rx_count - r0 == 2, "R5 two frames", rx_count - r0, 2);
            check(flags - f0 == (s == 0 ? 3 : 4), "R5 flag count",
                  flags - f0, (s == 0 ? 3 : 4));
        end

        // R6 full queue, dropped write
        begin
            int r0;
            tx_en = 1'b0; idle_mark = 1'b1;
            idle(20);
            for (int i = 0; i < 8; i++) push(8'h10 + 8'(i), i == 7, 1'b0);
            check(fifo_room == 1'b0, "R6 room low when full", fifo_room, 0);
            push(8'hAA, 1'b0, 1'b0);
            r0 = rx_count;
            tx_en = 1'b1;
            idle(300);
            check(rx_count == r0 + 1 && rx_len == 10 && rx_bytes[7] == 8'h17 && !underrun,
                  "R6 overflow write dropped", rx_len, 10);
            check(fifo_room == 1'b1, "R6 room back", fifo_room, 1);
        end

        // R7 underrun
        begin
            int r0, f0;
            idle_mark = 1'b0;
            idle(20);
            r0 = rx_count;
            push(8'h00, 1'b0, 1'b1);
            idle(60);
            check(underrun == 1'b1, "R7 underrun set", underrun, 1);
            check(last_run == 8, "R7 abort length", last_run, 8);
            f0 = flags;
            idle(40);
            check(flags > f0 && rx_count == r0, "R7 idle flags after", flags - f0, 4);
            // R10 sticky and clear
            check(underrun == 1'b1, "R10 underrun sticky", underrun, 1);
            clear_status();
            check(underrun == 1'b0, "R10 underrun cleared", underrun, 0);
        end

        // R8 software abort, normal and extended
        for (int e = 0; e < 2; e++) begin
            int r0;
            idle_mark = 1'b0; abort_ext = (e == 1);
            idle(20);
            r0 = rx_count;
            for (int i = 0; i < 8; i++) push(8'h00, 1'b0, 1'b1);
            idle(22);
            abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
            idle(300);
            check(last_run == (e ? 16 : 8), "R8 abort run", last_run, e ? 16 : 8);
            check(aborted && !underrun && rx_count == r0, "R8 flush and flag",
                  {aborted, underrun}, 2'b10);
            clear_status();
            check(!aborted, "R10 aborted cleared", aborted, 0);
        end
        abort_ext = 1'b0;

        // R9 clear-to-send loss mid-frame
        begin
            int bad, d0;
            idle_mark = 1'b1;
            idle(20);
            d0 = drops;
            for (int i = 0; i < 8; i++) push(8'h00, 1'b0, 1'b1);
            idle(22);
            cts_n = 1'b1;
            idle(2);
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                if (!txd) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R9 line high", bad, 0);
            check(drops == d0 + 1 && aborted, "R9 drop pulse and flag", drops - d0, 1);
            tx_en = 1'b0;
            cts_n = 1'b0;
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                if (!txd) bad++;
                @(negedge clk);
            end
            check(bad == 0 && !underrun, "R9 R1 disabled line idle", bad, 0);
            tx_en = 1'b1;
            clear_status();
        end

        idle(20);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule